// File: doc/BRIEF.md
# Pseudo-SRAM Asynchronous Access Controller

This block is clocked and turns single-word host requests into access cycles on the asynchronous SRAM-style pins of a 1M x 16 pseudo-static memory. The host places a request with a write flag, a 20-bit word address, 16-bit write data and two byte enables. It holds the request until the controller returns a one-clock acknowledge. For reads, the registered read data is valid from the acknowledge onward.

Each pin interval is a whole number of clocks. The controller gets that number by dividing the nanosecond limit by the clock-period parameter and rounding up. Every access is a fixed-length cycle with chip enable low. A recovery window with chip enable high follows every access. Because of that window, the memory's own rules hold without any extra tracking:

- the minimum and maximum cycle lengths,
- the chip-enable high pulse,
- the gap from a write strobe to a following output enable,
- output enable high before a write address appears.

The data bus is split into a driven value, a drive enable and a returned value, so that the pad ring can build the tri-state buffer.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_dq_oe` and `host_ack` are low, and `host_rdata` is zero.
- R2: A read request (host_we=0) with a nonzero byte-enable pair is accepted on the clock edge where it is seen in idle. From the next cycle, `mem_ce_n` and `mem_oe_n` stay low and `mem_we_n` stays high for ceil(max(70,60)/period) clocks, which is 9 at 8 ns. `mem_lb_n` is the inverse of host_be[0] (bits 7:0) and `mem_ub_n` is the inverse of host_be[1] (bits 15:8).
- R3: In the clock after a read's last low-chip-enable cycle, `host_ack` is high for exactly one clock. From that clock, `host_rdata` holds the sampled word, with the byte lanes whose enable was zero forced to zero.
- R4: A write request (host_we=1) keeps `mem_ce_n` and `mem_we_n` low for ceil(max(70,45)/period) clocks, which is 9 at 8 ns. `mem_oe_n` stays high through the write, and `host_ack` follows in the next clock.
- R5: `mem_dq_oe` is high only in the last ceil(15/period) clocks of a write strobe (2 at 8 ns), and then `mem_dq_out` equals the request's write data. At all other times `mem_dq_oe` is low.
- R6: `mem_addr` takes the request address at acceptance and does not change while `mem_ce_n` is low.
- R7: After every access, `mem_ce_n` stays high for at least ceil(10/period) clocks plus one idle clock before it can fall again. So a read's `mem_oe_n` falls at least that long after the previous `mem_we_n` rise.
- R8: A request with both byte enables zero is acknowledged one clock after acceptance. No strobe falls and `host_rdata` keeps its previous value. A write of this kind leaves the memory contents unchanged.
- R9: `mem_ce_n` is never low longer than ceil(1000/period) clocks. Chip enable low with both output enable and write enable high never persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 16 | Registered read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte select, active low |
| mem_ub_n | output | 1 | High byte select, active low |
| mem_addr | output | 20 | Memory word address |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Data returned from the bus |

## Verification
A wrong phase or counter value inside the controller shows up at the pins in the same clock, because every strobe comes straight from a register. The examples are a chip enable held one clock too long or too short, a data drive enable that is a cycle early, or output enable falling during a write. A bad lane mask or capture point appears in `host_rdata` at the acknowledge clock. A corrupted write appears on the next read of that word. The bench therefore predicts every pin on every clock of each access from the request alone, and reads back each written word.

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl #(
  parameter int CLK_NS     = 8,
  parameter int T_CYC_NS   = 70,
  parameter int T_ACC_NS   = 60,
  parameter int T_WP_NS    = 45,
  parameter int T_DS_NS    = 15,
  parameter int T_CP_NS    = 10,
  parameter int T_WHOL_NS  = 10,
  parameter int T_CEMAX_NS = 1000,
  parameter int AW         = 20,
  parameter int DW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [1:0]    host_be,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int BW      = DW / 2;
  localparam int C_CYC   = (T_CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_ACC   = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WP    = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_DS0   = (T_DS_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_CP0   = (T_CP_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WHOL  = (T_WHOL_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_CEMAX = T_CEMAX_NS / CLK_NS;
  localparam int C_RD    = (C_CYC > C_ACC) ? C_CYC : C_ACC;
  localparam int C_WR    = (C_CYC > C_WP) ? C_CYC : C_WP;
  localparam int C_DS    = (C_DS0 < 1) ? 1 : ((C_DS0 > C_WR) ? C_WR : C_DS0);
  localparam int C_CP    = (C_CP0 < 1) ? 1 : C_CP0;
  localparam int C_GAP   = (C_CP > C_WHOL) ? C_CP : C_WHOL;
  localparam int C_MAX   = (C_RD > C_WR) ? ((C_RD > C_GAP) ? C_RD : C_GAP)
                                         : ((C_WR > C_GAP) ? C_WR : C_GAP);
  localparam int CW      = $clog2(C_MAX + 1);

  localparam logic [CW-1:0] RD_LAST  = CW'(C_RD - 1);
  localparam logic [CW-1:0] WR_LAST  = CW'(C_WR - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(C_GAP - 1);
  localparam logic [CW-1:0] DS_FIRST = CW'(C_WR - C_DS);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_RCV} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [1:0]    be_q;
  logic [DW-1:0] lane_mask;

  assign lane_mask = {{BW{be_q[1]}}, {BW{be_q[0]}}};
  assign mem_dq_oe = (st == S_WR) && (cnt >= DS_FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      be_q       <= '0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      host_ack <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (host_req) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
            be_q       <= host_be;
            if (host_be == 2'b00) begin
              host_ack <= 1'b1;
              st       <= S_RCV;
            end else begin
              mem_ce_n <= 1'b0;
              mem_lb_n <= ~host_be[0];
              mem_ub_n <= ~host_be[1];
              if (host_we) begin
                mem_we_n <= 1'b0;
                st       <= S_WR;
              end else begin
                mem_oe_n <= 1'b0;
                st       <= S_RD;
              end
            end
          end
        end
        S_RD: begin
          if (cnt == RD_LAST) begin
            host_rdata <= mem_dq_in & lane_mask;
            host_ack   <= 1'b1;
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_lb_n   <= 1'b1;
            mem_ub_n   <= 1'b1;
            cnt        <= '0;
            st         <= S_RCV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WR: begin
          if (cnt == WR_LAST) begin
            host_ack <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
            cnt      <= '0;
            st       <= S_RCV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == GAP_LAST) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  localparam logic [11:0] SAT     = 12'hFFF;
  localparam logic [11:0] K_GAP   = 12'(C_CP);
  localparam logic [11:0] K_WHOL  = 12'(C_WHOL);
  localparam logic [11:0] K_CEMAX = 12'(C_CEMAX);

  logic [11:0] hi_run, lo_run, we_hi_run, odis_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run    <= SAT;
      lo_run    <= '0;
      we_hi_run <= SAT;
      odis_run  <= '0;
    end else begin
      hi_run    <= mem_ce_n ? ((hi_run == SAT) ? SAT : hi_run + 1'b1) : '0;
      lo_run    <= !mem_ce_n ? ((lo_run == SAT) ? SAT : lo_run + 1'b1) : '0;
      we_hi_run <= mem_we_n ? ((we_hi_run == SAT) ? SAT : we_hi_run + 1'b1) : '0;
      odis_run  <= (!mem_ce_n && mem_oe_n && mem_we_n)
                   ? ((odis_run == SAT) ? SAT : odis_run + 1'b1) : '0;
    end
  end

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r5_dq_only_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  a_r7_ce_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_run >= K_GAP));

  a_r7_we_to_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (we_hi_run >= K_WHOL));

  a_r9_ce_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run < K_CEMAX);

  a_r9_no_output_disable: assert property (@(posedge clk) disable iff (!rst_n)
    odis_run < K_CEMAX);

  a_r3_ack_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  a_r2_lanes_only_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n);

endmodule

// File: tb/tb_psram_async_ctrl.sv
module tb_psram_async_ctrl;

  localparam int PER   = 8;
  localparam int B_RD  = ((70 + PER - 1) / PER > (60 + PER - 1) / PER) ? (70 + PER - 1) / PER : (60 + PER - 1) / PER;
  localparam int B_WR  = ((70 + PER - 1) / PER > (45 + PER - 1) / PER) ? (70 + PER - 1) / PER : (45 + PER - 1) / PER;
  localparam int B_DS  = (15 + PER - 1) / PER;
  localparam int B_GAP = (10 + PER - 1) / PER;
  localparam int B_MAX = 1000 / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [19:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic        host_ack;
  logic [15:0] host_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  always #(PER / 2) clk = ~clk;

  psram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  logic [15:0] bmem [0:63];
  logic [15:0] emem [0:63];
  logic [15:0] last_rdata;
  int checks = 0;
  int errors = 0;
  int lo_run = 0;
  int lo_peak = 0;
  bit done = 1'b0;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? bmem[mem_addr[5:0]] : 16'h0000;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) bmem[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) bmem[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  always @(negedge clk) begin
    if (!mem_ce_n) lo_run = lo_run + 1;
    else lo_run = 0;
    if (lo_run > lo_peak) lo_peak = lo_run;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    int len;
    logic [15:0] m;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
    len = (be == 2'b00) ? 0 : (we ? B_WR : B_RD);
    m = {{8{be[1]}}, {8{be[0]}}};
    for (int i = 0; i < len + B_GAP; i++) begin
      @(negedge clk);
      if (i < len) begin
        chk("R2/R4 ce_n low in cycle", {31'b0, mem_ce_n}, 32'd0);
        chk("R2/R4 oe_n", {31'b0, mem_oe_n}, {31'b0, we});
        chk("R2/R4 we_n", {31'b0, mem_we_n}, {31'b0, ~we});
        chk("R2 lb_n", {31'b0, mem_lb_n}, {31'b0, ~be[0]});
        chk("R2 ub_n", {31'b0, mem_ub_n}, {31'b0, ~be[1]});
        chk("R6 addr", {12'b0, mem_addr}, {12'b0, a});
        chk("R5 dq_oe window", {31'b0, mem_dq_oe}, {31'b0, we && (i >= len - B_DS)});
        if (mem_dq_oe) chk("R5 dq_out", {16'b0, mem_dq_out}, {16'b0, d});
        chk("R3 no early ack", {31'b0, host_ack}, 32'd0);
      end else begin
        chk("R7 ce_n high in gap", {31'b0, mem_ce_n}, 32'd1);
        chk("R7 strobes idle", {28'b0, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'hF);
        chk("R5 dq released", {31'b0, mem_dq_oe}, 32'd0);
        chk("R3/R8 ack pulse", {31'b0, host_ack}, {31'b0, i == len});
        if (i == len) begin
          host_req = 1'b0;
          if (!we && be != 2'b00) last_rdata = emem[a[5:0]] & m;
          chk(be == 2'b00 ? "R8 rdata kept" : "R3 rdata", {16'b0, host_rdata}, {16'b0, last_rdata});
        end
      end
    end
    if (we) begin
      if (be[0]) emem[a[5:0]][7:0]  = d[7:0];
      if (be[1]) emem[a[5:0]][15:8] = d[15:8];
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int k = 0; k < 64; k++) begin
      bmem[k] = 16'(k * 16'h0101 + 16'h1357);
      emem[k] = bmem[k];
    end
    last_rdata = 16'h0000;
    repeat (4) @(negedge clk);
    chk("R1 strobes in reset", {27'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 strobes idle", {27'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
    chk("R1 dq_oe", {31'b0, mem_dq_oe}, 32'd0);
    chk("R1 ack", {31'b0, host_ack}, 32'd0);
    chk("R1 rdata", {16'b0, host_rdata}, 32'd0);

    access(1'b0, 20'h00003, 16'h0, 2'b11);
    access(1'b1, 20'h00003, 16'hBEEF, 2'b11);
    access(1'b0, 20'h00003, 16'h0, 2'b11);
    access(1'b1, 20'h00003, 16'h00A5, 2'b01);
    access(1'b0, 20'h00003, 16'h0, 2'b11);
    access(1'b1, 20'h80005, 16'h7700, 2'b10);
    access(1'b0, 20'h80005, 16'h0, 2'b01);
    access(1'b0, 20'h80005, 16'h0, 2'b10);
    access(1'b1, 20'h00009, 16'hDEAD, 2'b00);
    access(1'b0, 20'h00009, 16'h0, 2'b00);
    access(1'b0, 20'h00009, 16'h0, 2'b11);
    for (int n = 0; n < 6; n++) begin
      access(1'b1, 20'(n * 7 + 20'hFFFC0), 16'(n * 16'h1111 + 16'h0F0F), 2'b11);
      access(1'b0, 20'(n * 7 + 20'hFFFC0), 16'h0, 2'b11);
    end
    access(1'b0, 20'h00002, 16'h0, 2'b11);
    chk("R9 ce_n low run bound", lo_peak, (lo_peak <= B_MAX) ? lo_peak : B_MAX);
    summary();
  end

endmodule